// File: doc/BRIEF.md
# Descriptor Table Register Unit

This block keeps the base and limit registers for three descriptor tables of a 16-bit protected-mode CPU with a 24-bit physical address space: a global table, an interrupt table and a local table. A load request for the global or interrupt table names the address of a six-byte operand in memory. The block fetches that operand one byte at a time and then writes the register. A load request for the local table carries a 16-bit selector instead. The block finds the matching 8-byte descriptor inside the global table, checks it against the global limit, fetches it and copies its base and limit into the local register.

Only the most privileged level, level 0, may issue loads. Levels run from 0 to 3, and a numerically higher level has less privilege. A rejected or failed load leaves every register as it was. The block also has a combinational lookup port. For a table and an entry index it returns the entry's physical address, which is the base plus the index times 8. It reports a fault when the entry's last byte lies beyond the table limit. It also faults when the vector number is out of range for the interrupt table, or when the local table is not valid.

Top module: `dtr_unit`

## Requirements
- R1: After reset, all bases and limits are zero, the local table is marked invalid, and busy_o, done_o and fault_o are low.
- R2: A load with op 0 (global) or op 1 (interrupt) at privilege 0 reads six consecutive bytes starting at req_addr_i. Byte 0 is the low byte of the limit and byte 1 the high byte. Bytes 2 to 4 are the base, low byte first. With zero-wait responses the reads take one cycle each, and done_o pulses for one cycle seven cycles after the accepting edge, together with the new register value.
- R3: If the sixth operand byte is not zero, the load ends with fault_o and fault_code_o = 2, and the target register is unchanged.
- R4: A request with req_cpl_i other than 0 is answered one cycle later with fault_o and fault_code_o = 1. No bus read is issued and no register changes.
- R5: A load with op 2 takes the index from req_sel_i[15:3] and reads five bytes from global base + index*8. The limit comes from bytes 0 to 1 and the base from bytes 2 to 4, low byte first. The local table is then marked valid, and done_o arrives six cycles after the accepting edge.
- R6: A local load whose selector index is 0 clears the local base and limit, marks the local table invalid and pulses done_o one cycle later, with no bus read.
- R7: A local load whose descriptor end (index*8+7) exceeds the global limit faults one cycle later with fault_code_o = 2'd3 and no bus read. An index whose end equals the limit is accepted.
- R8: The lookup port returns lk_addr_o = base + lk_idx_i*8 combinationally for table code 0 (global), 1 (interrupt) or 2 (local). It raises lk_fault_o when lk_idx_i*8+7 exceeds that table's limit.
- R9: A lookup faults when it asks the interrupt table for an index of 256 or more, when it asks the local table while the local table is invalid, or when it uses table code 3. Table code 3 returns address 0.
- R10: Requests with op 3, and any request that arrives while busy_o is high, are ignored: no read, no done, no fault, no register change.
- R11: While a read is outstanding (mem_req_o high, mem_rvalid_i low), mem_req_o stays high and mem_addr_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request strobe |
| req_op_i | input | 2 | 0 global, 1 interrupt, 2 local, 3 none |
| req_cpl_i | input | 2 | Current privilege level of the requester |
| req_addr_i | input | 24 | Address of the six-byte operand |
| req_sel_i | input | 16 | Selector for a local table load |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 24 | Byte read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load completed (one-cycle pulse) |
| fault_o | output | 1 | Load rejected (one-cycle pulse) |
| fault_code_o | output | 2 | 1 privilege, 2 reserved byte, 3 limit |
| glb_base_o | output | 24 | Global table base |
| glb_limit_o | output | 16 | Global table limit |
| irq_base_o | output | 24 | Interrupt table base |
| irq_limit_o | output | 16 | Interrupt table limit |
| loc_base_o | output | 24 | Local table base |
| loc_limit_o | output | 16 | Local table limit |
| loc_valid_o | output | 1 | Local table holds a non-null descriptor |
| lk_tbl_i | input | 2 | Lookup table code |
| lk_idx_i | input | 13 | Lookup entry index |
| lk_addr_o | output | 24 | Entry physical address |
| lk_fault_o | output | 1 | Entry outside table or invalid |

## Verification
The assertions assume that mem_rvalid_i is only raised while mem_req_o is high. They also assume that the data arrives in the same cycle as mem_rvalid_i. The bench's memory model drives the response from mem_req_o alone, and it blocks it with a stall flag only while a load is in flight, so both assumptions always hold. Request inputs change only at falling edges. Every table address the bench uses stays inside its 256-byte memory, so the address wrap at the top of the 24-bit space is never reached.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  typedef enum logic [1:0] {OP_GLB = 2'd0, OP_IRQ = 2'd1, OP_LOC = 2'd2, OP_NONE = 2'd3} dtr_op_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_PRIV = 2'd1, FLT_RSVD = 2'd2, FLT_LIMIT = 2'd3} dtr_flt_e;
  typedef enum logic [1:0] {TBL_GLB = 2'd0, TBL_IRQ = 2'd1, TBL_LOC = 2'd2, TBL_BAD = 2'd3} dtr_tbl_e;
endpackage

// File: rtl/dtr_entry_chk.sv
module dtr_entry_chk #(
  parameter int unsigned AW  = 24,
  parameter int unsigned LW  = 16,
  parameter int unsigned IXW = 13
) (
  input  logic [AW-1:0]  base_i,
  input  logic [LW-1:0]  limit_i,
  input  logic [IXW-1:0] idx_i,
  output logic [AW-1:0]  addr_o,
  output logic           ovf_o
);
  localparam int unsigned EW = IXW + 3;
  logic [EW-1:0] first_off, last_off;

  assign first_off = {idx_i, 3'b000};
  assign last_off  = {idx_i, 3'b111};
  assign addr_o    = base_i + AW'(first_off);
  assign ovf_o     = 32'(last_off) > 32'(limit_i);
endmodule

// File: rtl/dtr_load_fsm.sv
module dtr_load_fsm
  import dtr_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  dtr_op_e       req_op_i,
  input  logic [1:0]    req_cpl_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          sel_null_i,
  input  logic          sel_ovf_i,
  input  logic [AW-1:0] loc_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          wr_en_o,
  output dtr_op_e       wr_op_o,
  output logic [AW-1:0] wr_base_o,
  output logic [LW-1:0] wr_limit_o,
  output logic          wr_valid_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o,
  output dtr_flt_e      fault_code_o
);
  localparam int unsigned LB = LW / 8;
  localparam int unsigned BB = AW / 8;
  localparam int unsigned NB = LB + BB + 1;
  localparam int unsigned CW = $clog2(NB);

  typedef enum logic {S_IDLE, S_READ} st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q, last_c;
  dtr_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    byte_q [LB+BB];
  logic          done_q, fault_q;
  dtr_flt_e      code_q;
  logic          accept, last_hit, rsvd_bad, null_ld;
  logic [AW-1:0] asm_base;
  logic [LW-1:0] asm_limit;

  assign accept   = (st_q == S_IDLE) && req_valid_i && (req_op_i != OP_NONE);
  assign null_ld  = accept && (req_cpl_i == 2'd0) && (req_op_i == OP_LOC) && sel_null_i;
  assign last_c   = (op_q == OP_LOC) ? CW'(LB + BB - 1) : CW'(NB - 1);
  assign last_hit = (st_q == S_READ) && mem_rvalid_i && (cnt_q == last_c);
  assign rsvd_bad = (op_q != OP_LOC) && (mem_rdata_i != 8'h00);

  // local descriptor: final base byte is taken straight from the bus
  always_comb begin
    for (int i = 0; i < LB; i++) asm_limit[8*i +: 8] = byte_q[i];
    for (int j = 0; j < BB; j++)
      asm_base[8*j +: 8] = (op_q == OP_LOC && j == BB - 1) ? mem_rdata_i : byte_q[LB+j];
  end

  assign mem_req_o    = (st_q == S_READ);
  assign mem_addr_o   = addr_q + AW'(cnt_q);
  assign busy_o       = (st_q == S_READ);
  assign wr_en_o      = null_ld || (last_hit && !rsvd_bad);
  assign wr_op_o      = (st_q == S_IDLE) ? req_op_i : op_q;
  assign wr_valid_o   = (st_q == S_READ);
  assign wr_base_o    = (st_q == S_READ) ? asm_base : '0;
  assign wr_limit_o   = (st_q == S_READ) ? asm_limit : '0;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= FLT_NONE;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (accept) begin
          if (req_cpl_i != 2'd0) begin
            fault_q <= 1'b1;
            code_q  <= FLT_PRIV;
          end else if (null_ld) begin
            done_q <= 1'b1;
          end else if (req_op_i == OP_LOC && sel_ovf_i) begin
            fault_q <= 1'b1;
            code_q  <= FLT_LIMIT;
          end else begin
            st_q   <= S_READ;
            cnt_q  <= '0;
            op_q   <= req_op_i;
            addr_q <= (req_op_i == OP_LOC) ? loc_addr_i : req_addr_i;
          end
        end
        S_READ: if (mem_rvalid_i) begin
          if (cnt_q == last_c) begin
            st_q <= S_IDLE;
            if (rsvd_bad) begin
              fault_q <= 1'b1;
              code_q  <= FLT_RSVD;
            end else begin
              done_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LB + BB; i++) byte_q[i] <= 8'h00;
    end else begin
      for (int i = 0; i < LB + BB; i++)
        if (st_q == S_READ && mem_rvalid_i && cnt_q == CW'(i)) byte_q[i] <= mem_rdata_i;
    end
  end
endmodule

// File: rtl/dtr_unit.sv
module dtr_unit
  import dtr_pkg::*;
#(
  parameter int unsigned AW    = 24,
  parameter int unsigned LW    = 16,
  parameter int unsigned SW    = 16,
  parameter int unsigned VEC_N = 256,
  localparam int unsigned IXW  = SW - 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [1:0]     req_op_i,
  input  logic [1:0]     req_cpl_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [SW-1:0]  req_sel_i,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  input  logic           mem_rvalid_i,
  input  logic [7:0]     mem_rdata_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           fault_o,
  output logic [1:0]     fault_code_o,
  output logic [AW-1:0]  glb_base_o,
  output logic [LW-1:0]  glb_limit_o,
  output logic [AW-1:0]  irq_base_o,
  output logic [LW-1:0]  irq_limit_o,
  output logic [AW-1:0]  loc_base_o,
  output logic [LW-1:0]  loc_limit_o,
  output logic           loc_valid_o,
  input  logic [1:0]     lk_tbl_i,
  input  logic [IXW-1:0] lk_idx_i,
  output logic [AW-1:0]  lk_addr_o,
  output logic           lk_fault_o
);
  localparam int unsigned NT = 3;

  logic [AW-1:0] glb_base_q, irq_base_q, loc_base_q;
  logic [LW-1:0] glb_limit_q, irq_limit_q, loc_limit_q;
  logic          loc_valid_q;

  logic [IXW-1:0] sel_idx;
  logic [AW-1:0]  loc_addr;
  logic           sel_ovf;
  logic           wr_en, wr_valid;
  dtr_op_e        wr_op;
  logic [AW-1:0]  wr_base;
  logic [LW-1:0]  wr_limit;
  dtr_flt_e       flt_code;

  assign sel_idx = req_sel_i[SW-1:3];

  dtr_entry_chk #(.AW(AW), .LW(LW), .IXW(IXW)) u_sel_chk (
    .base_i (glb_base_q),
    .limit_i(glb_limit_q),
    .idx_i  (sel_idx),
    .addr_o (loc_addr),
    .ovf_o  (sel_ovf)
  );

  dtr_load_fsm #(.AW(AW), .LW(LW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (dtr_op_e'(req_op_i)),
    .req_cpl_i   (req_cpl_i),
    .req_addr_i  (req_addr_i),
    .sel_null_i  (sel_idx == '0),
    .sel_ovf_i   (sel_ovf),
    .loc_addr_i  (loc_addr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .wr_en_o     (wr_en),
    .wr_op_o     (wr_op),
    .wr_base_o   (wr_base),
    .wr_limit_o  (wr_limit),
    .wr_valid_o  (wr_valid),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .fault_code_o(flt_code)
  );
  assign fault_code_o = flt_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_base_q  <= '0;
      glb_limit_q <= '0;
      irq_base_q  <= '0;
      irq_limit_q <= '0;
      loc_base_q  <= '0;
      loc_limit_q <= '0;
      loc_valid_q <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_op)
        OP_GLB: begin glb_base_q <= wr_base; glb_limit_q <= wr_limit; end
        OP_IRQ: begin irq_base_q <= wr_base; irq_limit_q <= wr_limit; end
        OP_LOC: begin
          loc_base_q  <= wr_base;
          loc_limit_q <= wr_limit;
          loc_valid_q <= wr_valid;
        end
        default: ;
      endcase
    end
  end

  // one address/limit checker per table for the lookup port
  logic [AW-1:0] t_base  [NT];
  logic [LW-1:0] t_limit [NT];
  logic [AW-1:0] t_addr  [NT];
  logic          t_ovf   [NT];

  assign t_base[0] = glb_base_q;  assign t_limit[0] = glb_limit_q;
  assign t_base[1] = irq_base_q;  assign t_limit[1] = irq_limit_q;
  assign t_base[2] = loc_base_q;  assign t_limit[2] = loc_limit_q;

  for (genvar g = 0; g < NT; g++) begin : g_lk
    dtr_entry_chk #(.AW(AW), .LW(LW), .IXW(IXW)) u_lk (
      .base_i (t_base[g]),
      .limit_i(t_limit[g]),
      .idx_i  (lk_idx_i),
      .addr_o (t_addr[g]),
      .ovf_o  (t_ovf[g])
    );
  end

  always_comb begin
    unique case (dtr_tbl_e'(lk_tbl_i))
      TBL_GLB: begin lk_addr_o = t_addr[0]; lk_fault_o = t_ovf[0]; end
      TBL_IRQ: begin
        lk_addr_o  = t_addr[1];
        lk_fault_o = t_ovf[1] || (32'(lk_idx_i) >= VEC_N);
      end
      TBL_LOC: begin lk_addr_o = t_addr[2]; lk_fault_o = t_ovf[2] || !loc_valid_q; end
      default: begin lk_addr_o = '0; lk_fault_o = 1'b1; end
    endcase
  end

  assign glb_base_o  = glb_base_q;
  assign glb_limit_o = glb_limit_q;
  assign irq_base_o  = irq_base_q;
  assign irq_limit_o = irq_limit_q;
  assign loc_base_o  = loc_base_q;
  assign loc_limit_o = loc_limit_q;
  assign loc_valid_o = loc_valid_q;
endmodule

// File: rtl/dtr_unit_chk.sv
module dtr_unit_chk #(
  parameter int unsigned AW  = 24,
  parameter int unsigned LW  = 16,
  parameter int unsigned IXW = 13
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic [1:0]     req_op_i,
  input logic [1:0]     req_cpl_i,
  input logic           mem_req_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           mem_rvalid_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           fault_o,
  input logic [1:0]     fault_code_o,
  input logic [AW-1:0]  glb_base_o,
  input logic [LW-1:0]  glb_limit_o,
  input logic [AW-1:0]  irq_base_o,
  input logic [LW-1:0]  irq_limit_o,
  input logic [AW-1:0]  loc_base_o,
  input logic [LW-1:0]  loc_limit_o,
  input logic           loc_valid_o,
  input logic [1:0]     lk_tbl_i,
  input logic [IXW-1:0] lk_idx_i,
  input logic           lk_fault_o
);
  AST_PRIV_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o && req_op_i != 2'd3 && req_cpl_i != 2'd0
      |=> fault_o && fault_code_o == 2'd1 && !mem_req_o) else $error("AST_PRIV_REJECT"); // R4

  AST_FAULT_KEEPS_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(glb_base_o) && $stable(glb_limit_o) && $stable(irq_base_o)
      && $stable(irq_limit_o) && $stable(loc_base_o) && $stable(loc_limit_o)) else $error("AST_FAULT_KEEPS_REGS"); // R3

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)) else $error("AST_DONE_FAULT_EXCL"); // R10

  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o) else $error("AST_IDLE_NO_READ"); // R10

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)) else $error("AST_READ_HOLD"); // R11

  AST_READ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i |=> !mem_req_o || mem_addr_o == $past(mem_addr_o) + AW'(1)) else $error("AST_READ_STEP"); // R2

  AST_NULL_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_valid_o |-> loc_base_o == '0 && loc_limit_o == '0) else $error("AST_NULL_LOCAL"); // R6

  AST_LK_GLB_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_tbl_i == 2'd0 && !lk_fault_o |-> 32'({lk_idx_i, 3'b111}) <= 32'(glb_limit_o)) else $error("AST_LK_GLB_LIMIT"); // R8

  AST_LK_LOC_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_tbl_i == 2'd2 && !loc_valid_o |-> lk_fault_o) else $error("AST_LK_LOC_VALID"); // R9
endmodule

bind dtr_unit dtr_unit_chk #(.AW(AW), .LW(LW), .IXW(IXW)) u_chk (.*);

// File: tb/dtr_unit_bench.sv
module dtr_unit_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0, req_cpl = 2'd0, fault_code, lk_tbl = 2'd0;
  logic [23:0] req_addr = '0, mem_addr, glb_base, irq_base, loc_base, lk_addr;
  logic [15:0] req_sel = '0, glb_limit, irq_limit, loc_limit;
  logic        mem_req, mem_rvalid, busy, done, fault, loc_valid, lk_fault;
  logic [7:0]  mem_rdata;
  logic [12:0] lk_idx = '0;
  logic        stall = 1'b0;
  logic [7:0]  mem [256];
  int          checks = 0, errors = 0, rd_cnt = 0;

  always #10 clk = ~clk;

  assign mem_rvalid = mem_req && !stall;
  assign mem_rdata  = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_req && mem_rvalid) rd_cnt <= rd_cnt + 1;

  dtr_unit u_dtr_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_cpl_i(req_cpl), .req_addr_i(req_addr), .req_sel_i(req_sel),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fault_o(fault),
    .fault_code_o(fault_code), .glb_base_o(glb_base), .glb_limit_o(glb_limit),
    .irq_base_o(irq_base), .irq_limit_o(irq_limit), .loc_base_o(loc_base),
    .loc_limit_o(loc_limit), .loc_valid_o(loc_valid), .lk_tbl_i(lk_tbl),
    .lk_idx_i(lk_idx), .lk_addr_o(lk_addr), .lk_fault_o(lk_fault)
  );

  // {table, index, expected address, expected fault}
  localparam logic [39:0] LK_TAB [7] = '{
    {2'd0, 13'd7,   24'h000078, 1'b0},   // R8
    {2'd0, 13'd8,   24'h000080, 1'b1},   // R8
    {2'd1, 13'd255, 24'h123C4E, 1'b0},   // R8
    {2'd1, 13'd256, 24'h123C56, 1'b1},   // R9
    {2'd2, 13'h1F,  24'h0F00F8, 1'b0},   // R8
    {2'd2, 13'h20,  24'h0F0100, 1'b1},   // R8
    {2'd3, 13'd0,   24'h000000, 1'b1}    // R9
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic run_load(input logic [1:0] op, input logic [1:0] cpl, input logic [23:0] a,
                          input logic [15:0] s, output int lat, output logic flt,
                          output logic [1:0] code, output logic one);
    @(negedge clk);
    rd_cnt = 0;
    req_op = op; req_cpl = cpl; req_addr = a; req_sel = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && !fault && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    flt  = fault;
    code = fault_code;
    @(negedge clk);
    one = !done && !fault;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic flt, one, seen;
    logic [1:0] code;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h10] = 8'h3F; mem[8'h11] = 8'h00; mem[8'h12] = 8'h40; mem[8'h13] = 8'h00; mem[8'h14] = 8'h00; mem[8'h15] = 8'h00;
    mem[8'h18] = 8'hFF; mem[8'h19] = 8'h0F; mem[8'h1A] = 8'h56; mem[8'h1B] = 8'h34; mem[8'h1C] = 8'h12; mem[8'h1D] = 8'h5A;
    mem[8'h20] = 8'hFF; mem[8'h21] = 8'h0F; mem[8'h22] = 8'h56; mem[8'h23] = 8'h34; mem[8'h24] = 8'h12; mem[8'h25] = 8'h00;
    mem[8'h50] = 8'h17; mem[8'h51] = 8'h00; mem[8'h52] = 8'hCD; mem[8'h53] = 8'hAB; mem[8'h54] = 8'h00;
    mem[8'h78] = 8'h00; mem[8'h79] = 8'h01; mem[8'h7A] = 8'h00; mem[8'h7B] = 8'h00; mem[8'h7C] = 8'h0F;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 glb_base", 32'(glb_base), 32'h0);
    chk("R1 glb_limit", 32'(glb_limit), 32'h0);
    chk("R1 irq_base", 32'(irq_base), 32'h0);
    chk("R1 irq_limit", 32'(irq_limit), 32'h0);
    chk("R1 loc_base", 32'(loc_base), 32'h0);
    chk("R1 loc_limit", 32'(loc_limit), 32'h0);
    chk("R1 loc_valid", 32'(loc_valid), 32'h0);
    chk("R1 busy/done/fault", 32'({busy, done, fault}), 32'h0);
    lk_tbl = 2'd0; lk_idx = 13'd0; #1;
    chk("R8 zero limit lookup fault", 32'(lk_fault), 32'h1);

    // R4 privilege rejection
    run_load(2'd0, 2'd3, 24'h10, 16'h0, lat, flt, code, one);
    chk("R4 fault", 32'(flt), 32'h1);
    chk("R4 code", 32'(code), 32'h1);
    chk("R4 latency", 32'(lat), 32'd1);
    chk("R4 no read", 32'(rd_cnt), 32'd0);
    chk("R4 glb_limit kept", 32'(glb_limit), 32'h0);

    // R2 global load
    run_load(2'd0, 2'd0, 24'h10, 16'h0, lat, flt, code, one);
    chk("R2 done", 32'(flt), 32'h0);
    chk("R2 latency", 32'(lat), 32'd7);
    chk("R2 reads", 32'(rd_cnt), 32'd6);
    chk("R2 one-cycle pulse", 32'(one), 32'h1);
    chk("R2 glb_base", 32'(glb_base), 32'h000040);
    chk("R2 glb_limit", 32'(glb_limit), 32'h003F);

    // R3 nonzero reserved byte
    run_load(2'd1, 2'd0, 24'h18, 16'h0, lat, flt, code, one);
    chk("R3 fault", 32'(flt), 32'h1);
    chk("R3 code", 32'(code), 32'h2);
    chk("R3 irq_base kept", 32'(irq_base), 32'h0);
    chk("R3 irq_limit kept", 32'(irq_limit), 32'h0);

    // R2 interrupt load
    run_load(2'd1, 2'd0, 24'h20, 16'h0, lat, flt, code, one);
    chk("R2 irq done", 32'(flt), 32'h0);
    chk("R2 irq_base", 32'(irq_base), 32'h123456);
    chk("R2 irq_limit", 32'(irq_limit), 32'h0FFF);

    // R5 local load, index 2
    run_load(2'd2, 2'd0, 24'h0, 16'h0013, lat, flt, code, one);
    chk("R5 done", 32'(flt), 32'h0);
    chk("R5 latency", 32'(lat), 32'd6);
    chk("R5 reads", 32'(rd_cnt), 32'd5);
    chk("R5 loc_base", 32'(loc_base), 32'h00ABCD);
    chk("R5 loc_limit", 32'(loc_limit), 32'h0017);
    chk("R5 loc_valid", 32'(loc_valid), 32'h1);

    // R7 index 8 exceeds global limit
    run_load(2'd2, 2'd0, 24'h0, 16'h0040, lat, flt, code, one);
    chk("R7 fault", 32'(flt), 32'h1);
    chk("R7 code", 32'(code), 32'h3);
    chk("R7 latency", 32'(lat), 32'd1);
    chk("R7 no read", 32'(rd_cnt), 32'd0);
    chk("R7 loc_limit kept", 32'(loc_limit), 32'h0017);

    // R7 boundary: index 7 ends exactly at limit
    run_load(2'd2, 2'd0, 24'h0, 16'h003B, lat, flt, code, one);
    chk("R7 boundary accepted", 32'(flt), 32'h0);
    chk("R5 loc_base idx7", 32'(loc_base), 32'h0F0000);
    chk("R5 loc_limit idx7", 32'(loc_limit), 32'h0100);

    // lookup vectors
    foreach (LK_TAB[k]) begin
      @(negedge clk);
      lk_tbl = LK_TAB[k][39:38];
      lk_idx = LK_TAB[k][37:25];
      #1;
      chk("R8/R9 lookup addr", 32'(lk_addr), 32'(LK_TAB[k][24:1]));
      chk("R8/R9 lookup fault", 32'(lk_fault), 32'(LK_TAB[k][0]));
    end

    // R10 op 3 ignored
    @(negedge clk);
    rd_cnt = 0; seen = 1'b0;
    req_op = 2'd3; req_cpl = 2'd0; req_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      seen = seen | busy | done | fault;
    end
    req_valid = 1'b0;
    chk("R10 op3 no activity", 32'(seen), 32'h0);
    chk("R10 op3 no read", 32'(rd_cnt), 32'd0);
    chk("R10 op3 glb_base kept", 32'(glb_base), 32'h000040);

    // R10 requests while busy ignored
    @(negedge clk);
    req_op = 2'd0; req_cpl = 2'd0; req_addr = 24'h10; req_valid = 1'b1;
    @(negedge clk);
    req_cpl = 2'd3;
    seen = 1'b0; lat = 1;
    while (!done && lat < 60) begin
      seen = seen | fault;
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk("R10 no fault while busy", 32'(seen | fault), 32'h0);
    chk("R10 load completed", 32'(done), 32'h1);

    // R11 stalled read holds request and address
    @(negedge clk);
    rd_cnt = 0;
    req_op = 2'd1; req_cpl = 2'd0; req_addr = 24'h20; req_valid = 1'b1;
    stall = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0;
    repeat (3) begin
      @(negedge clk);
      seen = seen | !mem_req | (mem_addr != 24'h20);
    end
    chk("R11 hold during stall", 32'(seen), 32'h0);
    stall = 1'b0;
    lat = 0;
    while (!done && !fault && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 done after stall", 32'(done), 32'h1);
    chk("R11 irq_base", 32'(irq_base), 32'h123456);

    // R6 null selector
    run_load(2'd2, 2'd0, 24'h0, 16'h0002, lat, flt, code, one);
    chk("R6 done", 32'(flt), 32'h0);
    chk("R6 latency", 32'(lat), 32'd1);
    chk("R6 no read", 32'(rd_cnt), 32'd0);
    chk("R6 loc_valid", 32'(loc_valid), 32'h0);
    chk("R6 loc_base", 32'(loc_base), 32'h0);
    chk("R6 loc_limit", 32'(loc_limit), 32'h0);
    @(negedge clk);
    lk_tbl = 2'd2; lk_idx = 13'd0; #1;
    chk("R9 invalid local lookup", 32'(lk_fault), 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule